// File: doc/BRIEF.md
# I2C Register-Pointer Slave

This block is a synchronous I2C target. It connects an external register file to a two-wire bus. A system clock oversamples SCL and SDA. The block recognises START, repeated START and STOP, and it answers one fixed 7-bit address (0x48). It keeps an 8-bit register pointer. The first byte of a write sets the pointer. Each later data byte is stored at the pointer, and the pointer then steps forward by one. A read sends the pointed register and moves to the next register each time the master acknowledges.

The block also takes two reset requests: a reserved pointer value, and a general-call command. Either request starts a timed reload of default values. During the reload the block drives SDA for nothing. The register file watches `busy` and restores its defaults when `busy` rises. SDA is open-drain: the block only ever pulls the line low, through `sda_oe`.

Top module: `i2c_ptr_slave`

## Requirements
- R1: The block acknowledges address byte 0x90 (write) and 0x91 (read), which is 7-bit address 0x48 sent MSB first. It acknowledges by holding `sda_oe` high through the ninth clock. Any other non-zero address byte gets no acknowledge.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START restarts address decoding exactly as a START does.
- R3: In a write, the byte after the address is acknowledged and loaded into the pointer. Each following data byte is acknowledged and produces a one-cycle `reg_we` at `reg_addr` = pointer, with `reg_wdata` = byte. The pointer then increments.
- R4: In a read, the byte at the pointer goes out MSB first. A master ACK increments the pointer and the next register is sent. A master NACK returns the block to idle with the pointer unchanged.
- R5: Every STOP returns the block to idle and clears the pointer to 0x00, so a read that follows starts at register 0.
- R6: A data byte written while the pointer is NREGS or higher is acknowledged, but no `reg_we` is issued.
- R7: Pointer byte 0xBF is acknowledged and starts the default reload. `busy` goes high and the pointer is not changed.
- R8: Address byte 0x00 (general call) is acknowledged. A following byte 0x06 is acknowledged and starts the reload. Any other following byte gets no acknowledge.
- R9: While `busy` is high, which lasts RELOAD_CYCLES clocks, `sda_oe` stays low and `reg_we` stays low, so every byte goes unacknowledged.
- R10: A read keeps advancing the pointer past the last register. It sends whatever `reg_rdata` returns, until the master gives a NACK, START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low (open-drain) |
| reg_addr | output | 8 | Register pointer, used as the register-file address |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register-file contents at `reg_addr` |
| busy | output | 1 | Default reload in progress |

## Verification
The hardest case to reach is a byte that arrives during the reload window. The reset word is ACKed, then a STOP follows. Straight after that STOP the bench opens a new transaction and sends the address byte. RELOAD_CYCLES is set larger than one byte time, so this byte lands inside the window, and the bench checks that it gets no acknowledge. Only after the window closes does a read show that the registers hold their defaults again.

The other hard case is the pointer after a NACK. This leaves no trace at the ports until a later read. The bench reaches it with a repeated START straight after the NACKed byte, and checks that the same register comes out again.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_RXACK,
    S_TX,
    S_TXACK
  } st_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA,
    K_GC
  } kind_t;

  localparam logic [6:0] DEV_ADDR   = 7'h48;
  localparam logic [7:0] RESET_WORD = 8'hBF;
  localparam logic [7:0] GC_RESET   = 8'h06;
  localparam logic [7:0] GC_ADDR    = 8'h00;
endpackage

// File: rtl/i2c_ptr_sync.sv
module i2c_ptr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw;
  logic [1:0] synced;
  logic [1:0] last;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) last <= 2'b11;
    else     last <= synced;
  end

  assign scl_s     = synced[1];
  assign sda_s     = synced[0];
  assign scl_rise  = synced[1] & ~last[1];
  assign scl_fall  = ~synced[1] & last[1];
  assign start_det = synced[1] & last[1] & last[0] & ~synced[0];
  assign stop_det  = synced[1] & last[1] & ~last[0] & synced[0];
endmodule

// File: rtl/i2c_ptr_reload.sv
module i2c_ptr_reload #(
  parameter int CYCLES = 7500
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (go)         cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
  import i2c_ptr_pkg::*;
#(
  parameter int NREGS         = 8,
  parameter int RELOAD_CYCLES = 7500,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata,
  output logic       busy
);
  localparam logic [8:0] NREGS_L = 9'(NREGS);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic reload_go;

  st_t        st;
  kind_t      kind;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [7:0] txsh;
  logic [7:0] ptr;
  logic       rd_mode;
  logic       rst_pend;
  logic       inc_pend;

  i2c_ptr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_ptr_reload #(.CYCLES(RELOAD_CYCLES)) u_reload (
    .clk(clk), .rst(rst), .go(reload_go), .busy(busy)
  );

  assign reg_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      kind      <= K_ADDR;
      bitcnt    <= '0;
      shreg     <= '0;
      txsh      <= '0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      rd_mode   <= 1'b0;
      rst_pend  <= 1'b0;
      inc_pend  <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
      reload_go <= 1'b0;
    end else begin
      reg_we    <= 1'b0;
      reload_go <= 1'b0;
      if (busy) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        if (stop_det) ptr <= '0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        ptr    <= '0;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st       <= S_RX;
        kind     <= K_ADDR;
        bitcnt   <= '0;
        sda_oe   <= 1'b0;
        rd_mode  <= 1'b0;
        rst_pend <= 1'b0;
        inc_pend <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              case (kind)
                K_ADDR: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    sda_oe  <= 1'b1;
                    st      <= S_RXACK;
                    rd_mode <= shreg[0];
                    kind    <= K_PTR;
                  end else if (shreg == GC_ADDR) begin
                    sda_oe <= 1'b1;
                    st     <= S_RXACK;
                    kind   <= K_GC;
                  end else begin
                    st <= S_IDLE;
                  end
                end
                K_PTR: begin
                  sda_oe <= 1'b1;
                  st     <= S_RXACK;
                  kind   <= K_DATA;
                  if (shreg == RESET_WORD) rst_pend <= 1'b1;
                  else                     ptr      <= shreg;
                end
                K_DATA: begin
                  sda_oe   <= 1'b1;
                  st       <= S_RXACK;
                  inc_pend <= 1'b1;
                  if ({1'b0, ptr} < NREGS_L) begin
                    reg_we    <= 1'b1;
                    reg_wdata <= shreg;
                  end
                end
                default: begin
                  if (shreg == GC_RESET) begin
                    sda_oe   <= 1'b1;
                    st       <= S_RXACK;
                    rst_pend <= 1'b1;
                  end else begin
                    st <= S_IDLE;
                  end
                end
              endcase
            end
          end
          S_RXACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              if (inc_pend) begin
                ptr      <= ptr + 1'b1;
                inc_pend <= 1'b0;
              end
              if (rst_pend) begin
                reload_go <= 1'b1;
                rst_pend  <= 1'b0;
                st        <= S_IDLE;
              end else if (rd_mode) begin
                txsh   <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
                bitcnt <= '0;
                st     <= S_TX;
              end else begin
                st <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= S_TXACK;
              end else begin
                txsh   <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          S_TXACK: begin
            if (scl_rise) begin
              if (!sda_s) ptr <= ptr + 1'b1;
              else        st  <= S_IDLE;
            end else if (scl_fall) begin
              txsh   <= reg_rdata;
              sda_oe <= ~reg_rdata[7];
              bitcnt <= '0;
              st     <= S_TX;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_ptr_slave_chk.sv
module i2c_ptr_slave_chk #(
  parameter int NREGS = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       sda_oe,
  input logic       reg_we,
  input logic [7:0] reg_addr,
  input logic       busy,
  input logic       stop_det
);
  AST_WE_IN_RANGE: assert property (@(posedge clk) disable iff (rst) reg_we |-> ({1'b0, reg_addr} < 9'(NREGS))); // R6
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst) reg_we |=> !reg_we); // R3
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst) busy |-> !sda_oe); // R9
  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (rst) busy |-> !reg_we); // R9
  AST_STOP_CLEARS_PTR: assert property (@(posedge clk) disable iff (rst) stop_det |=> (reg_addr == 8'h00)); // R5
endmodule

bind i2c_ptr_slave i2c_ptr_slave_chk #(.NREGS(NREGS)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .reg_we(reg_we),
  .reg_addr(reg_addr), .busy(busy), .stop_det(stop_det)
);

// File: tb/i2c_ptr_slave_test.sv
module i2c_ptr_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS      = 8;
  localparam int RELOAD     = 2000;
  localparam int Q          = 10;
  localparam int IW         = $clog2(NREGS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe, reg_we, busy;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [NREGS];
  logic busy_q;
  int checks = 0;
  int fails = 0;
  int bad_we = 0;
  int bad_oe = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_ptr_slave #(.NREGS(NREGS), .RELOAD_CYCLES(RELOAD), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .busy(busy)
  );

  // behavioural register file: defaults 0xA0+i, reload when busy rises
  always_ff @(posedge clk) begin
    busy_q <= busy;
    if (rst || (busy && !busy_q)) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= 8'hA0 + 8'(i);
    end else if (reg_we && reg_addr < NREGS) begin
      mem[reg_addr[IW-1:0]] <= reg_wdata;
    end
  end
  assign reg_rdata = (reg_addr < NREGS) ? mem[reg_addr[IW-1:0]] : 8'hEE;

  // per-clock reference: no out-of-range write, no drive while reloading
  always @(negedge clk) begin
    if (!rst) begin
      if (reg_we && reg_addr >= NREGS) bad_we++;
      if (busy && sda_oe) bad_oe++;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; w(Q);
    scl_m = 1'b1; w(Q);
    sda_m = 1'b0; w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; w(Q);
    scl_m = 1'b1; w(Q);
    sda_m = 1'b1; w(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q);
      scl_m = 1'b1; w(2*Q);
      scl_m = 1'b0; w(Q);
    end
    sda_m = 1'b1; w(Q);
    scl_m = 1'b1; w(Q);
    ack = ~sda_line; w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q);
      scl_m = 1'b1; w(Q);
      b[i] = sda_line; w(Q);
      scl_m = 1'b0; w(Q);
    end
    sda_m = ~give_ack; w(Q);
    scl_m = 1'b1; w(2*Q);
    scl_m = 1'b0; w(Q);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    w(5);
    rst = 1'b0;
    w(5);
    check("reset sda_oe", {7'd0, sda_oe}, 8'h00);
    check("reset busy", {7'd0, busy}, 8'h00);
    check("reset pointer", reg_addr, 8'h00);

    // R1 R3: write pointer 2, two data bytes
    i2c_start;
    wbyte(8'h90, a); check("R1 write addr ack", {7'd0, a}, 8'h01);
    wbyte(8'h02, a); check("R3 pointer ack", {7'd0, a}, 8'h01);
    wbyte(8'h11, a); check("R3 data ack", {7'd0, a}, 8'h01);
    wbyte(8'h22, a); check("R3 data ack 2", {7'd0, a}, 8'h01);
    i2c_stop;

    // R1: foreign address ignored
    i2c_start;
    wbyte(8'h92, a); check("R1 foreign addr nack", {7'd0, a}, 8'h00);
    i2c_stop;

    // R5 R4: read after STOP starts at 0
    i2c_start;
    wbyte(8'h91, a); check("R1 read addr ack", {7'd0, a}, 8'h01);
    rbyte(1'b1, d); check("R5 read reg0", d, 8'hA0);
    rbyte(1'b1, d); check("R4 read reg1", d, 8'hA1);
    rbyte(1'b1, d); check("R3 read reg2", d, 8'h11);
    rbyte(1'b0, d); check("R3 read reg3", d, 8'h22);
    i2c_stop;

    // R2 R4: repeated START, NACK keeps pointer
    i2c_start;
    wbyte(8'h90, a);
    wbyte(8'h05, a);
    i2c_start;
    wbyte(8'h91, a); check("R2 repeated start ack", {7'd0, a}, 8'h01);
    rbyte(1'b1, d); check("R2 read reg5", d, 8'hA5);
    rbyte(1'b0, d); check("R4 read reg6", d, 8'hA6);
    i2c_start;
    wbyte(8'h91, a);
    rbyte(1'b0, d); check("R4 nack no increment", d, 8'hA6);
    i2c_stop;

    // R6: write running past the end
    i2c_start;
    wbyte(8'h90, a);
    wbyte(8'h07, a);
    wbyte(8'h33, a); check("R3 write reg7 ack", {7'd0, a}, 8'h01);
    wbyte(8'h44, a); check("R6 invalid addr ack", {7'd0, a}, 8'h01);
    i2c_stop;

    // R10: read past the end
    i2c_start;
    wbyte(8'h90, a);
    wbyte(8'h07, a);
    i2c_start;
    wbyte(8'h91, a);
    rbyte(1'b1, d); check("R6 reg7 kept first byte", d, 8'h33);
    rbyte(1'b1, d); check("R10 read beyond end", d, 8'hEE);
    rbyte(1'b0, d); check("R10 read beyond end 2", d, 8'hEE);
    i2c_stop;

    // R8: general call with another byte
    i2c_start;
    wbyte(8'h00, a); check("R8 general call ack", {7'd0, a}, 8'h01);
    wbyte(8'h07, a); check("R8 other command nack", {7'd0, a}, 8'h00);
    i2c_stop;
    w(5);
    check("R8 no reload on other command", {7'd0, busy}, 8'h00);

    // R7 R9: reset word, silence during reload
    i2c_start;
    wbyte(8'h90, a);
    wbyte(8'hBF, a); check("R7 reset word ack", {7'd0, a}, 8'h01);
    i2c_stop;
    check("R7 busy after reset word", {7'd0, busy}, 8'h01);
    i2c_start;
    wbyte(8'h90, a); check("R9 nack while busy", {7'd0, a}, 8'h00);
    i2c_stop;
    w(RELOAD + 50);
    check("R9 busy ends", {7'd0, busy}, 8'h00);
    i2c_start;
    wbyte(8'h90, a);
    wbyte(8'h02, a);
    i2c_start;
    wbyte(8'h91, a); check("R9 ack after reload", {7'd0, a}, 8'h01);
    rbyte(1'b1, d); check("R7 reg2 default", d, 8'hA2);
    rbyte(1'b0, d); check("R7 reg3 default", d, 8'hA3);
    i2c_stop;

    // R8: general call reset
    i2c_start;
    wbyte(8'h90, a);
    wbyte(8'h04, a);
    wbyte(8'h55, a);
    i2c_stop;
    i2c_start;
    wbyte(8'h00, a);
    wbyte(8'h06, a); check("R8 reset command ack", {7'd0, a}, 8'h01);
    i2c_stop;
    check("R8 busy after general call", {7'd0, busy}, 8'h01);
    w(RELOAD + 50);
    i2c_start;
    wbyte(8'h90, a);
    wbyte(8'h04, a);
    i2c_start;
    wbyte(8'h91, a);
    rbyte(1'b0, d); check("R8 reg4 default", d, 8'hA4);
    i2c_stop;

    check("R6 no out-of-range strobe", 8'(bad_we), 8'h00);
    check("R9 no drive while busy", 8'(bad_oe), 8'h00);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule